// File: doc/BRIEF.md
# Multi-Block Trace Store with Fill and Hit Logic

This block keeps short dynamic instruction sequences that run across up to three conditional branches, so that a fetch stage can obtain instructions from several basic blocks in one access. Lines are built by a fill unit that watches the stream of retired instructions. Each retired instruction carries its address, its word, whether it is a conditional branch, the direction it went, its taken target, and whether it is a branch with many possible targets (return, indirect jump, trap). The fill unit collects instructions in a line buffer and writes a line into a small direct-mapped store when the trace is complete.

A lookup presents a fetch address and three branch predictions. One cycle later the block reports whether a stored line starts at that address and agrees with the predictions. On a hit it returns the instruction words, the number of valid words, and the address to fetch next. Predictions are given per branch in trace order, `lk_pred[i]` for the branch with ordinal i counted from zero, and 1 means taken.

Top module: `trace_cache`

## Requirements
- R1: After reset, `res_valid` and `res_hit` are 0 and every line is empty, so any lookup misses until a line is filled.
- R2: A lookup presented with `lk_valid` high at a clock edge yields `res_valid` high for exactly the following cycle; without a request `res_valid` stays low.
- R3: A trace is written when its third conditional branch is retired; that branch is the line's last word and the count equals the number of words retired since the trace began.
- R4: A trace is written when its sixteenth word is retired, whether or not it holds a branch.
- R5: A retired many-target branch is not stored; it closes the open trace (if any) and that line's fall-through address is the last stored word's address plus 4. With no open trace it has no effect.
- R6: A hit requires a valid line whose stored tag equals fetch address bits above the index; a different address mapping to the same line misses.
- R7: A hit requires `lk_pred[i]` to equal the recorded direction of every interior branch i (every branch except a final branch that is the line's last word); any disagreement, including a trace that matches only in its prefix, is a miss.
- R8: For a line whose last word is a conditional branch, the next fetch address is that branch's taken target if its prediction is 1, otherwise the branch address plus 4.
- R9: For a line whose last word is not a branch, the next fetch address is the last word's address plus 4 for every prediction value.
- R10: The line index is fetch address bits [4:2] (with 8 lines); filling a trace at an index replaces the previous line there, which then misses.
- R11: On a hit `res_count` is the stored word count and slot k of `res_instr` (bits 32k+31..32k) holds the k-th stored word, unused slots zero; on a miss `res_count`, `res_next` and `res_instr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | AW | Fetch address of the lookup |
| lk_pred | input | 3 | Predicted directions, bit i for branch i, 1 = taken |
| rt_valid | input | 1 | Retired instruction present |
| rt_addr | input | AW | Address of the retired instruction |
| rt_instr | input | IW | Instruction word |
| rt_cond | input | 1 | Instruction is a conditional branch |
| rt_taken | input | 1 | Direction the conditional branch went |
| rt_target | input | AW | Taken target of the conditional branch |
| rt_multi | input | 1 | Instruction is a many-target branch |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Lookup hit |
| res_count | output | CW | Number of valid instruction words |
| res_instr | output | MAXI*IW | Instruction words, slot 0 in the low bits |
| res_next | output | AW | Next fetch address |

## Verification
Lines are built from four trace shapes: one closed by its third branch, a branch-free run closed by the word limit, a short run closed by a many-target branch after a not-taken branch, and a single taken branch closed the same way. Each line is probed with prediction patterns that agree fully, differ only on the final branch (which must change the next address and not the hit), and differ on an interior branch (which must miss). Aliasing addresses, a replacing fill at a used index, a lone many-target branch and a reset with lines present separate tag, replacement and clearing errors from matching errors.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_MAXB = 3;

  typedef struct packed {
    logic [1:0]         nbr;      // conditional branches in the line
    logic               ends_br;  // last word is a conditional branch
    logic [TC_MAXB-1:0] dir;      // recorded direction per branch ordinal
  } tc_flags_t;
endpackage

// File: rtl/tc_fill.sv
module tc_fill
  import tc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IW   = 32,
  parameter int MAXI = 16,
  parameter int CW   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rt_valid,
  input  logic [AW-1:0]     rt_addr,
  input  logic [IW-1:0]     rt_instr,
  input  logic              rt_cond,
  input  logic              rt_taken,
  input  logic [AW-1:0]     rt_target,
  input  logic              rt_multi,
  output logic              wr_en,
  output logic [AW-1:0]     wr_start,
  output tc_flags_t         wr_flags,
  output logic [CW-1:0]     wr_count,
  output logic [AW-1:0]     wr_fall,
  output logic [AW-1:0]     wr_taken,
  output logic [MAXI*IW-1:0] wr_data
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [MAXI*IW-1:0] buf_data, app_data;
  logic [CW-1:0]      buf_cnt, app_cnt;
  logic [1:0]         buf_nbr, app_nbr;
  logic [TC_MAXB-1:0] buf_dir, app_dir;
  logic [AW-1:0]      buf_start, buf_fall, buf_tkn;
  logic               buf_last_br;
  logic               term_full, flush;
  logic [AW-1:0]      rt_fall, rt_tkn;

  assign rt_fall = rt_addr + STEP;
  assign rt_tkn  = rt_cond ? rt_target : rt_fall;

  always_comb begin
    app_data = buf_data;
    for (int k = 0; k < MAXI; k++)
      if (CW'(k) == buf_cnt) app_data[k*IW +: IW] = rt_instr;
    app_dir = buf_dir;
    for (int b = 0; b < TC_MAXB; b++)
      if (rt_cond && 2'(b) == buf_nbr) app_dir[b] = rt_taken;
    app_cnt = buf_cnt + CW'(1);
    app_nbr = buf_nbr + 2'(rt_cond);
  end

  assign term_full = rt_valid && !rt_multi &&
                     (app_cnt == CW'(MAXI) || app_nbr == 2'(TC_MAXB));
  assign flush     = rt_valid && rt_multi && (buf_cnt != '0);
  assign wr_en     = term_full || flush;

  always_comb begin
    if (flush) begin
      wr_data  = buf_data;
      wr_count = buf_cnt;
      wr_flags = '{nbr: buf_nbr, ends_br: buf_last_br, dir: buf_dir};
      wr_start = buf_start;
      wr_fall  = buf_fall;
      wr_taken = buf_tkn;
    end else begin
      wr_data  = app_data;
      wr_count = app_cnt;
      wr_flags = '{nbr: app_nbr, ends_br: rt_cond, dir: app_dir};
      wr_start = (buf_cnt == '0) ? rt_addr : buf_start;
      wr_fall  = rt_fall;
      wr_taken = rt_tkn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_data    <= '0;
      buf_cnt     <= '0;
      buf_nbr     <= '0;
      buf_dir     <= '0;
      buf_start   <= '0;
      buf_fall    <= '0;
      buf_tkn     <= '0;
      buf_last_br <= 1'b0;
    end else if (rt_valid) begin
      if (rt_multi || term_full) begin
        buf_data <= '0;
        buf_cnt  <= '0;
        buf_nbr  <= '0;
        buf_dir  <= '0;
      end else begin
        buf_data    <= app_data;
        buf_cnt     <= app_cnt;
        buf_nbr     <= app_nbr;
        buf_dir     <= app_dir;
        buf_fall    <= rt_fall;
        buf_tkn     <= rt_tkn;
        buf_last_br <= rt_cond;
        if (buf_cnt == '0) buf_start <= rt_addr;
      end
    end
  end
endmodule

// File: rtl/tc_store.sv
module tc_store
  import tc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IW    = 32,
  parameter int MAXI  = 16,
  parameter int CW    = 5,
  parameter int LINES = 8,
  parameter int IDXW  = 3,
  parameter int TAGW  = 27
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDXW-1:0]    widx,
  input  logic [TAGW-1:0]    wtag,
  input  tc_flags_t          wflags,
  input  logic [CW-1:0]      wcount,
  input  logic [AW-1:0]      wfall,
  input  logic [AW-1:0]      wtaken,
  input  logic [MAXI*IW-1:0] wdata,
  input  logic               re,
  input  logic [IDXW-1:0]    ridx,
  output logic               rvalid,
  output logic [TAGW-1:0]    rtag,
  output tc_flags_t          rflags,
  output logic [CW-1:0]      rcount,
  output logic [AW-1:0]      rfall,
  output logic [AW-1:0]      rtaken,
  output logic [MAXI*IW-1:0] rdata
);
  localparam int FW = $bits(tc_flags_t);
  localparam int MW = TAGW + FW + CW + 2*AW;

  logic [MW-1:0]      meta_mem [LINES];
  logic [MAXI*IW-1:0] data_mem [LINES];
  logic [LINES-1:0]   vld;
  logic [MW-1:0]      rmeta;

  always_ff @(posedge clk) begin
    if (we) begin
      meta_mem[widx] <= {wtag, wflags, wcount, wfall, wtaken};
      data_mem[widx] <= wdata;
    end
    if (re) begin
      rmeta <= meta_mem[ridx];
      rdata <= data_mem[ridx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= '0;
      rvalid <= 1'b0;
    end else begin
      if (re) rvalid <= vld[ridx];
      if (we) vld[widx] <= 1'b1;
    end
  end

  assign {rtag, rflags, rcount, rfall, rtaken} = rmeta;
endmodule

// File: rtl/tc_match.sv
module tc_match
  import tc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int TAGW = 27
) (
  input  logic               line_valid,
  input  logic [TAGW-1:0]    line_tag,
  input  tc_flags_t          line_flags,
  input  logic [AW-1:0]      line_fall,
  input  logic [AW-1:0]      line_taken,
  input  logic [TAGW-1:0]    req_tag,
  input  logic [TC_MAXB-1:0] req_pred,
  output logic               hit,
  output logic [AW-1:0]      next_addr
);
  logic [1:0] n_int;
  logic       dir_ok, final_pred;

  assign n_int = line_flags.ends_br ? line_flags.nbr - 2'd1 : line_flags.nbr;

  always_comb begin
    dir_ok     = 1'b1;
    final_pred = 1'b0;
    for (int b = 0; b < TC_MAXB; b++) begin
      if (2'(b) < n_int && req_pred[b] != line_flags.dir[b]) dir_ok = 1'b0;
      if (2'(b) == line_flags.nbr - 2'd1) final_pred = req_pred[b];
    end
  end

  assign hit       = line_valid && (line_tag == req_tag) && dir_ok;
  assign next_addr = (line_flags.ends_br && final_pred) ? line_taken : line_fall;
endmodule

// File: rtl/trace_cache.sv
module trace_cache
  import tc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IW    = 32,
  parameter int MAXI  = 16,
  parameter int LINES = 8,
  localparam int CW   = $clog2(MAXI + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [AW-1:0]      lk_addr,
  input  logic [2:0]         lk_pred,
  input  logic               rt_valid,
  input  logic [AW-1:0]      rt_addr,
  input  logic [IW-1:0]      rt_instr,
  input  logic               rt_cond,
  input  logic               rt_taken,
  input  logic [AW-1:0]      rt_target,
  input  logic               rt_multi,
  output logic               res_valid,
  output logic               res_hit,
  output logic [CW-1:0]      res_count,
  output logic [MAXI*IW-1:0] res_instr,
  output logic [AW-1:0]      res_next
);
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - IDXW - 2;

  logic               f_wr_en;
  logic [AW-1:0]      f_start, f_fall, f_taken;
  tc_flags_t          f_flags;
  logic [CW-1:0]      f_count;
  logic [MAXI*IW-1:0] f_data;

  logic               s_valid;
  logic [TAGW-1:0]    s_tag;
  tc_flags_t          s_flags;
  logic [CW-1:0]      s_count;
  logic [AW-1:0]      s_fall, s_taken;
  logic [MAXI*IW-1:0] s_data;

  logic               q_valid;
  logic [TAGW-1:0]    q_tag;
  logic [2:0]         q_pred;
  logic               m_hit;
  logic [AW-1:0]      m_next;

  tc_fill #(.AW(AW), .IW(IW), .MAXI(MAXI), .CW(CW)) i_fill (
    .clk, .rst, .rt_valid, .rt_addr, .rt_instr, .rt_cond, .rt_taken,
    .rt_target, .rt_multi,
    .wr_en(f_wr_en), .wr_start(f_start), .wr_flags(f_flags),
    .wr_count(f_count), .wr_fall(f_fall), .wr_taken(f_taken), .wr_data(f_data)
  );

  tc_store #(.AW(AW), .IW(IW), .MAXI(MAXI), .CW(CW), .LINES(LINES),
             .IDXW(IDXW), .TAGW(TAGW)) i_store (
    .clk, .rst,
    .we(f_wr_en), .widx(f_start[IDXW+1:2]), .wtag(f_start[AW-1:IDXW+2]),
    .wflags(f_flags), .wcount(f_count), .wfall(f_fall), .wtaken(f_taken),
    .wdata(f_data),
    .re(lk_valid), .ridx(lk_addr[IDXW+1:2]),
    .rvalid(s_valid), .rtag(s_tag), .rflags(s_flags), .rcount(s_count),
    .rfall(s_fall), .rtaken(s_taken), .rdata(s_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
      q_pred  <= '0;
    end else begin
      q_valid <= lk_valid;
      if (lk_valid) begin
        q_tag  <= lk_addr[AW-1:IDXW+2];
        q_pred <= lk_pred;
      end
    end
  end

  tc_match #(.AW(AW), .TAGW(TAGW)) i_match (
    .line_valid(s_valid), .line_tag(s_tag), .line_flags(s_flags),
    .line_fall(s_fall), .line_taken(s_taken),
    .req_tag(q_tag), .req_pred(q_pred),
    .hit(m_hit), .next_addr(m_next)
  );

  assign res_valid = q_valid;
  assign res_hit   = q_valid && m_hit;
  assign res_count = res_hit ? s_count : '0;
  assign res_instr = res_hit ? s_data  : '0;
  assign res_next  = res_hit ? m_next  : '0;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int AW   = 32,
  parameter int MAXI = 16,
  localparam int CW  = $clog2(MAXI + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic          res_valid,
  input logic          res_hit,
  input logic [CW-1:0] res_count,
  input logic [AW-1:0] res_next,
  input logic          wr_en,
  input logic [CW-1:0] wr_count,
  input logic [1:0]    wr_nbr
);
  a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);
  a_r11_miss_empty: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_count == '0 && res_next == '0));
  a_r11_hit_nonempty: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_count != '0 && res_count <= CW'(MAXI)));
  a_r1_hit_needs_result: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);
  a_r3_line_limits: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_nbr <= 2'd3 && wr_count != '0 && wr_count <= CW'(MAXI)));
endmodule

bind trace_cache tc_checker #(.AW(AW), .MAXI(MAXI)) i_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .res_valid(res_valid),
  .res_hit(res_hit), .res_count(res_count), .res_next(res_next),
  .wr_en(f_wr_en), .wr_count(f_count), .wr_nbr(f_flags.nbr)
);

// File: tb/test_trace_cache.sv
module test_trace_cache;
  localparam int AW = 32, IW = 32, MAXI = 16, LINES = 8, CW = 5;
  localparam logic [31:0] KEY = 32'hA500_0000;

  typedef struct packed {
    logic [31:0] addr;
    logic [2:0]  pred;
    logic        hit;
    logic [4:0]  cnt;
    logic [31:0] nxt;
    logic [31:0] lastpc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h100, 3'b101, 1'b1, 5'd6,  32'h300, 32'h20C}, // R3 R8 taken final
    '{32'h100, 3'b001, 1'b1, 5'd6,  32'h210, 32'h20C}, // R8 final not taken
    '{32'h100, 3'b011, 1'b0, 5'd0,  32'h0,   32'h0},   // R7 second differs
    '{32'h100, 3'b100, 1'b0, 5'd0,  32'h0,   32'h0},   // R7 first differs
    '{32'h404, 3'b000, 1'b1, 5'd16, 32'h444, 32'h440}, // R4 R9
    '{32'h404, 3'b111, 1'b1, 5'd16, 32'h444, 32'h440}, // R9
    '{32'h508, 3'b000, 1'b1, 5'd2,  32'h510, 32'h50C}, // R5
    '{32'h508, 3'b001, 1'b0, 5'd0,  32'h0,   32'h0},   // R7 prefix only
    '{32'h60C, 3'b001, 1'b1, 5'd1,  32'h700, 32'h60C}, // R8 R5
    '{32'h60C, 3'b000, 1'b1, 5'd1,  32'h610, 32'h60C}, // R8
    '{32'h140, 3'b101, 1'b0, 5'd0,  32'h0,   32'h0},   // R6 alias
    '{32'h714, 3'b000, 1'b0, 5'd0,  32'h0,   32'h0}    // R5 lone
  };

  logic clk = 0, rst = 1;
  logic lk_valid = 0; logic [31:0] lk_addr = 0; logic [2:0] lk_pred = 0;
  logic rt_valid = 0, rt_cond = 0, rt_taken = 0, rt_multi = 0;
  logic [31:0] rt_addr = 0, rt_instr = 0, rt_target = 0;
  logic res_valid, res_hit; logic [CW-1:0] res_count;
  logic [MAXI*IW-1:0] res_instr; logic [31:0] res_next;

  int checks = 0, failures = 0;
  logic g_v, g_h; logic [CW-1:0] g_c; logic [31:0] g_n; logic [MAXI*IW-1:0] g_i;

  always #2 clk = ~clk;

  trace_cache #(.AW(AW), .IW(IW), .MAXI(MAXI), .LINES(LINES)) i_trace_cache (
    .clk, .rst, .lk_valid, .lk_addr, .lk_pred, .rt_valid, .rt_addr, .rt_instr,
    .rt_cond, .rt_taken, .rt_target, .rt_multi,
    .res_valid, .res_hit, .res_count, .res_instr, .res_next);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic retire(input [31:0] a, input bit c, input bit t,
                        input [31:0] tg, input bit m);
    @(negedge clk);
    rt_valid = 1; rt_addr = a; rt_instr = a ^ KEY; rt_cond = c;
    rt_taken = t; rt_target = tg; rt_multi = m;
    @(negedge clk);
    rt_valid = 0; rt_cond = 0; rt_multi = 0;
  endtask

  task automatic lookup(input [31:0] a, input [2:0] p);
    @(negedge clk);
    lk_valid = 1; lk_addr = a; lk_pred = p;
    @(negedge clk);
    lk_valid = 0;
    g_v = res_valid; g_h = res_hit; g_c = res_count; g_n = res_next; g_i = res_instr;
  endtask

  task automatic expect_line(input string req, input logic h, input int c,
                             input [31:0] nx, input [31:0] first, input [31:0] last);
    chk(g_v == 1'b1, "R2 result valid", 64'(g_v), 64'd1);
    chk(g_h == h, {req, " hit"}, 64'(g_h), 64'(h));
    chk(g_c == CW'(c), {req, " count"}, 64'(g_c), 64'(c));
    chk(g_n == nx, {req, " next"}, 64'(g_n), 64'(nx));
    if (h) begin
      chk(g_i[31:0] == (first ^ KEY), "R11 slot0", 64'(g_i[31:0]), 64'(first ^ KEY));
      chk(g_i[(c-1)*32 +: 32] == (last ^ KEY), "R11 last slot",
          64'(g_i[(c-1)*32 +: 32]), 64'(last ^ KEY));
      if (c < MAXI)
        chk(g_i[c*32 +: 32] == 32'h0, "R11 unused slot", 64'(g_i[c*32 +: 32]), 64'd0);
    end else
      chk(g_i == '0, "R11 miss words", 64'(g_i[63:0]), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(res_valid == 0 && res_hit == 0, "R1 reset outputs", 64'(res_valid), 64'd0);
    rst = 0;
    lookup(32'h010, 3'b000);
    expect_line("R1 empty after reset", 0, 0, 0, 0, 0);
    @(negedge clk);
    chk(res_valid == 0, "R2 single pulse", 64'(res_valid), 64'd0);

    // three-branch trace
    retire(32'h100, 0, 0, 0, 0);
    retire(32'h104, 1, 1, 32'h200, 0);
    retire(32'h200, 0, 0, 0, 0);
    retire(32'h204, 1, 0, 32'h280, 0);
    retire(32'h208, 0, 0, 0, 0);
    retire(32'h20C, 1, 1, 32'h300, 0);
    // sixteen plain words
    for (int k = 0; k < 16; k++) retire(32'h404 + 32'(k*4), 0, 0, 0, 0);
    // closed by many-target branch after a plain word
    retire(32'h508, 1, 0, 32'h600, 0);
    retire(32'h50C, 0, 0, 0, 0);
    retire(32'h510, 0, 0, 0, 1);
    // single taken branch closed by many-target branch
    retire(32'h60C, 1, 1, 32'h700, 0);
    retire(32'h700, 0, 0, 0, 1);
    // lone many-target branch
    retire(32'h714, 0, 0, 0, 1);

    for (int v = 0; v < NV; v++) begin
      lookup(VECS[v].addr, VECS[v].pred);
      expect_line("R7 R8 R9 table", VECS[v].hit, int'(VECS[v].cnt), VECS[v].nxt,
                  VECS[v].addr, VECS[v].lastpc);
    end

    // R10 replacement at index 0
    retire(32'h120, 0, 0, 0, 0);
    retire(32'h124, 0, 0, 0, 1);
    lookup(32'h100, 3'b101);
    expect_line("R10 replaced line", 0, 0, 0, 0, 0);
    lookup(32'h120, 3'b111);
    expect_line("R10 new line", 1, 1, 32'h124, 32'h120, 32'h120);

    // R1 reset clears lines
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    lookup(32'h404, 3'b000);
    expect_line("R1 cleared by reset", 0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule